// File: doc/BRIEF.md
# Coincidence Sync Pulse Generator

This block runs on a fast reference clock and produces two divided bank clocks, bank A and bank C, each with its own period in reference ticks. Their ratio need not be an integer. Alongside them it drives an active-low sync strobe. The strobe warns downstream logic that a cycle is coming in which both bank clocks rise together. The low pulse lasts one period of whichever bank clock is faster. It sits directly before the shared rising edge, and the strobe returns high on that edge.

The common-edge spacing is the least common multiple of the two periods. The block does not compute it arithmetically. It measures the spacing by counting ticks from one common edge to the next, and it stays quiet while it measures. A new divisor pair is taken up only at a common rising edge. Each take-up starts a fresh measurement, so the strobe never shows a cut-short pulse. A freeze-enable input holds the strobe inactive without disturbing the bank clocks.

Top module: `coinc_sync`

## Requirements
- R1: Each sync pulse, when not interrupted by the freeze-enable, stays low for exactly min(PA, PC) reference ticks. PA and PC are the active bank periods.
- R2: Let L = lcm(PA, PC) and take tick 0 as the common rising edge at which the active divisors were adopted. From the second hyperperiod on, `syncN` is low exactly at the ticks whose offset within the hyperperiod is L-min(PA, PC) or greater.
- R3: `syncN` returns high in the same tick in which both `bankClkA` and `bankClkC` rise.
- R4: The divisor inputs are unsigned periods in reference ticks, and a value of 0 or 1 is treated as 2. Each bank clock is high during the first floor(P/2) ticks of its period and low for the rest, and it rises at the start of each period.
- R5: The pulse repeats once in every hyperperiod for any pair of periods. When PA equals PC the window covers the whole hyperperiod, so `syncN` stays low from the second period on.
- R6: During reset, `syncN` is high and both bank clocks are high. After reset, both banks run with period 2 until the first common edge (tick 2). There they adopt the input divisors. `syncN` then stays high through the first full hyperperiod.
- R7: A divisor change takes effect at the first common rising edge whose preceding tick saw the new value. A pulse already under way completes, and `syncN` stays high for the following hyperperiod. Writing the currently active values causes no restart.
- R8: While `syncEn` is low, `syncN` is high. The bank clocks and the hyperperiod timing are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Fast reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| divA | input | DIV_W | Bank A period in reference ticks |
| divC | input | DIV_W | Bank C period in reference ticks |
| syncEn | input | 1 | Sync strobe enable; low holds `syncN` high |
| bankClkA | output | 1 | Regenerated bank A clock |
| bankClkC | output | 1 | Regenerated bank C clock |
| syncN | output | 1 | Active-low coincidence strobe |

## Verification
The hardest case to reach from the ports is a divisor change that lands while a pulse is already low. The change must wait for the common edge that ends that pulse and then silence the next hyperperiod. The bench counts reference ticks from reset release, so it knows where each pulse falls for the chosen periods. It writes the new divisors in the middle of such a pulse. Later it repeats the same trick with the freeze-enable, dropping it inside a pulse and restoring it in the middle of another hyperperiod.

// File: rtl/coinc_sync_pkg.sv
package coinc_sync_pkg;
  localparam int NUM_BANKS = 2;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic restart;  // adopt new divisors at this common edge
    logic capture;  // latch the measured hyperperiod length
    logic armed;    // a valid hyperperiod length is held
  } ctlStrobe_t;
endpackage

// File: rtl/coinc_sync_dp.sv
module coinc_sync_dp
  import coinc_sync_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divA,
  input  logic [DIV_W-1:0] divC,
  input  logic             syncEn,
  input  ctlStrobe_t       ctl,
  output logic             wrapBoth,
  output logic             divChanged,
  output logic             bankClkA,
  output logic             bankClkC,
  output logic             syncN
);
  localparam int HP_W = 2 * DIV_W;
  localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

  logic [NUM_BANKS*DIV_W-1:0] rawFlat;
  logic [NUM_BANKS*DIV_W-1:0] actFlat;
  logic [NUM_BANKS-1:0]       wrapVec;
  logic [NUM_BANKS-1:0]       clkVec;
  logic [NUM_BANKS-1:0]       diffVec;

  assign rawFlat = {divC, divA};

  // One phase counter per bank clock
  for (genvar g = 0; g < NUM_BANKS; g++) begin : gBank
    logic [DIV_W-1:0] reqDiv;
    logic [DIV_W-1:0] actDiv;
    logic [DIV_W-1:0] phase;

    assign reqDiv = (rawFlat[g*DIV_W +: DIV_W] < MIN_DIV) ? MIN_DIV
                                                          : rawFlat[g*DIV_W +: DIV_W];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        actDiv <= MIN_DIV;
        phase  <= '0;
      end else begin
        if (ctl.restart) actDiv <= reqDiv;
        phase <= wrapVec[g] ? '0 : phase + 1'b1;
      end
    end

    assign wrapVec[g] = (phase == actDiv - 1'b1);
    assign clkVec[g]  = (phase < (actDiv >> 1));
    assign diffVec[g] = (reqDiv != actDiv);
    assign actFlat[g*DIV_W +: DIV_W] = actDiv;
  end

  assign wrapBoth   = &wrapVec;
  assign divChanged = |diffVec;
  assign bankClkA   = clkVec[0];
  assign bankClkC   = clkVec[1];

  // Hyperperiod tracking
  logic [DIV_W-1:0] perA;
  logic [DIV_W-1:0] perC;
  logic [DIV_W-1:0] minPer;
  logic [HP_W-1:0]  hpCnt;
  logic [HP_W-1:0]  hpLen;
  logic [HP_W-1:0]  lowStart;

  assign perA   = actFlat[DIV_W-1:0];
  assign perC   = actFlat[2*DIV_W-1:DIV_W];
  assign minPer = (perA < perC) ? perA : perC;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hpCnt <= '0;
      hpLen <= '0;
    end else begin
      hpCnt <= wrapBoth ? '0 : hpCnt + 1'b1;
      if (ctl.capture) hpLen <= hpCnt + 1'b1;
    end
  end

  assign lowStart = hpLen - {{(HP_W-DIV_W){1'b0}}, minPer};
  assign syncN    = ~(ctl.armed & syncEn & (hpCnt >= lowStart));
endmodule

// File: rtl/coinc_sync_ctl.sv
module coinc_sync_ctl
  import coinc_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrapBoth,
  input  logic       divChanged,
  output ctlStrobe_t ctl
);
  logic armed;

  always_comb begin
    ctl.restart = wrapBoth & divChanged;
    ctl.capture = wrapBoth & ~divChanged & ~armed;
    ctl.armed   = armed;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            armed <= 1'b0;
    else if (ctl.restart) armed <= 1'b0;
    else if (ctl.capture) armed <= 1'b1;
  end
endmodule

// File: rtl/coinc_sync.sv
module coinc_sync
  import coinc_sync_pkg::*;
#(
  parameter int DIV_W = 5
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divA,
  input  logic [DIV_W-1:0] divC,
  input  logic             syncEn,
  output logic             bankClkA,
  output logic             bankClkC,
  output logic             syncN
);
  ctlStrobe_t ctl;
  logic       wrapBoth;
  logic       divChanged;

  coinc_sync_ctl u_ctl (
    .clk       (refClk),
    .rstN      (rstN),
    .wrapBoth  (wrapBoth),
    .divChanged(divChanged),
    .ctl       (ctl)
  );

  coinc_sync_dp #(.DIV_W(DIV_W)) u_dp (
    .clk       (refClk),
    .rstN      (rstN),
    .divA      (divA),
    .divC      (divC),
    .syncEn    (syncEn),
    .ctl       (ctl),
    .wrapBoth  (wrapBoth),
    .divChanged(divChanged),
    .bankClkA  (bankClkA),
    .bankClkC  (bankClkC),
    .syncN     (syncN)
  );
endmodule

// File: rtl/coinc_sync_chk.sv
module coinc_sync_chk (
  input logic refClk,
  input logic rstN,
  input logic syncEn,
  input logic bankClkA,
  input logic bankClkC,
  input logic syncN
);
  logic       prevA;
  logic       prevC;
  logic [1:0] coinCnt;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      prevA   <= 1'b1;
      prevC   <= 1'b1;
      coinCnt <= '0;
    end else begin
      prevA <= bankClkA;
      prevC <= bankClkC;
      if (bankClkA && bankClkC && !prevA && !prevC && coinCnt != 2'd3)
        coinCnt <= coinCnt + 1'b1;
    end
  end

  AST_SYNC_RISE_ALIGNED: assert property (@(posedge refClk) disable iff (!rstN)
    ($rose(syncN) && syncEn && $past(syncEn)) |-> ($rose(bankClkA) && $rose(bankClkC))); // R3

  AST_FROZEN_IDLE: assert property (@(posedge refClk) disable iff (!rstN)
    !syncEn |-> syncN); // R8

  AST_NO_EARLY_PULSE: assert property (@(posedge refClk) disable iff (!rstN)
    !syncN |-> (coinCnt != 2'd0 || ($rose(bankClkA) && $rose(bankClkC)))); // R6

  AST_NO_RUNT_PULSE: assert property (@(posedge refClk) disable iff (!rstN)
    ($fell(syncN) && syncEn && $past(syncEn)) |=> (!syncN || !syncEn)); // R1
endmodule

bind coinc_sync coinc_sync_chk u_chk (
  .refClk  (refClk),
  .rstN    (rstN),
  .syncEn  (syncEn),
  .bankClkA(bankClkA),
  .bankClkC(bankClkC),
  .syncN   (syncN)
);

// File: tb/sim_coinc_sync.sv
module sim_coinc_sync;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 5;

  logic             refClk = 1'b0;
  logic             rstN = 1'b0;
  logic [DIV_W-1:0] divA = '0;
  logic [DIV_W-1:0] divC = '0;
  logic             syncEn = 1'b1;
  logic             bankClkA;
  logic             bankClkC;
  logic             syncN;

  coinc_sync #(.DIV_W(DIV_W)) u0 (
    .refClk(refClk), .rstN(rstN), .divA(divA), .divC(divC), .syncEn(syncEn),
    .bankClkA(bankClkA), .bankClkC(bankClkC), .syncN(syncN)
  );

  always #(CLK_PERIOD/2) refClk = ~refClk;

  int total = 0;
  int fails = 0;

  // Expectation model state, derived from the requirements
  int k, s, actA, actC, tgtA, tgtC, hpL, minM, lowRun;
  bit prevSync, prevClkA, prevClkC, prevEn, cleanRun;
  string holdTag;

  function automatic int gcdf(int a, int b);
    while (b != 0) begin
      int t = a % b;
      a = b;
      b = t;
    end
    return a;
  endfunction

  function automatic int lcmf(int a, int b);
    return (a / gcdf(a, b)) * b;
  endfunction

  function automatic int clampf(int v);
    return (v < 2) ? 2 : v;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at tick %0d: got %0d expected %0d", tag, k, act, exp);
    end
  endtask

  task automatic setInputs(int a, int c);
    divA = DIV_W'(a);
    divC = DIV_W'(c);
    tgtA = clampf(a);
    tgtC = clampf(c);
  endtask

  task automatic doReset(int a, int c);
    rstN = 1'b0;
    syncEn = 1'b1;
    setInputs(a, c);
    repeat (3) @(posedge refClk);
    @(negedge refClk);
    chk(syncN == 1'b1, "R6 syncN in reset", int'(syncN), 1);
    chk(bankClkA == 1'b1 && bankClkC == 1'b1, "R6 bank clocks in reset",
        int'({bankClkA, bankClkC}), 3);
    rstN = 1'b1;
    k = 0; s = 0; actA = 2; actC = 2; hpL = 2; minM = 2;
    prevSync = 1'b1; prevClkA = 1'b1; prevClkC = 1'b1; prevEn = 1'b1;
    lowRun = 0; cleanRun = 1'b1;
    holdTag = "R6";
  endtask

  task automatic tick();
    bit rs;
    int oldM, n, ph;
    bit expA, expC, expLow;
    string tag;
    rs = (((k + 1 - s) % hpL) == 0) && (tgtA != actA || tgtC != actC);
    oldM = minM;
    @(posedge refClk);
    @(negedge refClk);
    k++;
    if (rs) begin
      s = k; actA = tgtA; actC = tgtC;
      hpL = lcmf(actA, actC);
      minM = (actA < actC) ? actA : actC;
    end
    expA = ((k - s) % actA) < (actA / 2);
    expC = ((k - s) % actC) < (actC / 2);
    chk(bankClkA == expA, "R4 bankClkA", int'(bankClkA), int'(expA));
    chk(bankClkC == expC, "R4 bankClkC", int'(bankClkC), int'(expC));
    n = (k - s) / hpL;
    ph = (k - s) % hpL;
    expLow = syncEn && n >= 1 && ph >= hpL - minM;
    if (!syncEn)     tag = "R8 syncN frozen";
    else if (n == 0) tag = holdTag;
    else if (n >= 2) tag = "R5 syncN repeat";
    else             tag = "R2 syncN window";
    chk(syncN == !expLow, tag, int'(syncN), int'(!expLow));
    if (!prevSync && syncN && syncEn && prevEn) begin
      chk(bankClkA && bankClkC && !prevClkA && !prevClkC, "R3 rise aligned",
          int'({prevClkA, prevClkC, bankClkA, bankClkC}), 3);
      if (cleanRun) chk(lowRun == oldM, "R1 pulse width", lowRun, oldM);
    end
    if (syncN) begin
      lowRun = 0;
      cleanRun = syncEn;
    end else begin
      lowRun++;
    end
    prevSync = syncN; prevClkA = bankClkA; prevClkC = bankClkC; prevEn = syncEn;
  endtask

  task automatic runTicks(int nTicks);
    for (int i = 0; i < nTicks; i++) tick();
  endtask

  // R2 R5 R6: fixed ratio pairs from reset
  task automatic testRatio(int a, int c);
    doReset(a, c);
    runTicks(2 + 4 * lcmf(clampf(a), clampf(c)));
  endtask

  // R4: out-of-range divisors clamp to 2
  task automatic testClamp();
    doReset(0, 1);
    runTicks(12);
    doReset(1, 6);
    runTicks(30);
  endtask

  // R7: change inside a live pulse, then a rewrite of the same values
  task automatic testChange();
    doReset(4, 6);      // adopted at tick 2, L=12, pulse ticks 22..25
    runTicks(23);
    holdTag = "R7 quiet after change";
    setInputs(6, 8);    // new epoch at tick 26, L=24
    runTicks(3 * 24 + 5);
    setInputs(6, 8);    // no restart expected
    runTicks(30);
    setInputs(2, 3);
    runTicks(3 * 6 + 20);
  endtask

  // R8: freeze inside a pulse and release mid-hyperperiod
  task automatic testFreeze();
    doReset(2, 6);      // L=6, pulse ticks 12,13 then 18,19
    runTicks(12);
    syncEn = 1'b0;
    runTicks(8);
    syncEn = 1'b1;
    runTicks(20);
    syncEn = 1'b0;
    runTicks(3);
    syncEn = 1'b1;
    runTicks(12);
  endtask

  initial begin
    testRatio(4, 6);
    testRatio(4, 4);
    testRatio(4, 8);
    testRatio(2, 6);
    testRatio(8, 2);
    testRatio(6, 8);
    testRatio(2, 12);
    testRatio(6, 4);
    testRatio(2, 2);
    testRatio(5, 3);
    testClamp();
    testChange();
    testFreeze();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge refClk);
    total++;
    fails++;
    $display("FAIL watchdog expired: got 1 expected 0");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule